// File: doc/BRIEF.md
# Byte Write Merger for Wear-Limited Nonvolatile Memory

This block takes single-byte write requests and turns them into as few physical program operations as it can. It compares each requested byte with the value already stored and marks only the bytes that change. It also collects bytes that land in the same aligned group of eight addresses into one program command. The command carries a group base address, eight data lanes and a lane enable mask.

A group is committed when a request targets another group, or when the flush input is raised. A group whose mask ends up empty is dropped, so no program operation is issued for it. Each program operation holds the memory for a fixed window. The default window is 20 ms at the system clock, and the count of cycles is a parameter. New requests are held off for the whole window.

A host read port returns the byte the memory will hold once the pending group is written, because it overlays the buffered bytes on the stored ones. A saturating counter records how many program operations have been issued, so the wear that is saved can be measured.

Top module: `nvm_write_merger`

## Requirements
- R1: A byte whose requested value equals the stored value leaves its lane enable bit clear. A group whose enable mask is all zero is dropped without a program operation, and `wear_count` does not change.
- R2: Writes whose addresses share every bit above bits [2:0] are merged into one command. Bits [2:0] pick the lane: mask bit k enables lane k, and lane k is `pgm_data[8k+7:8k]`. Lanes that are not enabled carry zero. The last write to a lane wins.
- R3: Writing 4096 sequential bytes that all differ from the stored contents, followed by a flush, issues exactly 512 program operations.
- R4: When a request to a different group is accepted while the pending mask is nonzero, `pgm_go` is high for one cycle in the next cycle. `pgm_base` is then the old group address with bits [2:0] zero, and the accepted byte starts the new pending group.
- R5: When `flush_req` is high, the block is not busy and the pending mask is nonzero, the group is committed (`pgm_go` in the next cycle) and the pending mask is emptied. A flush with an empty mask issues nothing.
- R6: After a commit, `pgm_busy` is high and `req_ready` is low for exactly PROG_CYCLES cycles, starting with the cycle in which `pgm_go` is high. While the block is busy, flush and requests have no effect.
- R7: `req_ready` is low in any cycle in which `flush_req` is high, so a flush takes priority over a request in the same cycle.
- R8: `host_rdata` returns the buffered byte when `host_raddr` falls in the pending group on an enabled lane. Otherwise it returns the stored byte.
- R9: `wear_count` rises by one for each program operation and holds at its all-ones value once it reaches it.
- R10: Writing a pending lane back to its stored value clears that lane's enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte write request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_addr | input | AW | Byte address of the request |
| req_data | input | 8 | Byte to write |
| flush_req | input | 1 | Commit the pending group |
| host_raddr | input | AW | Host read address |
| host_rdata | output | 8 | Host read data, with the pending bytes overlaid |
| mem_cmp_addr | output | AW | Memory read address used for the compare |
| mem_cmp_data | input | 8 | Stored byte at mem_cmp_addr (combinational) |
| mem_look_addr | output | AW | Memory read address for the host port |
| mem_look_data | input | 8 | Stored byte at mem_look_addr (combinational) |
| pgm_go | output | 1 | One-cycle program command strobe |
| pgm_base | output | AW | Group base address, bits [2:0] zero |
| pgm_data | output | 8*GROUP_BYTES | Lane data, lane k in bits [8k+7:8k] |
| pgm_mask | output | GROUP_BYTES | Lane enable mask |
| pgm_busy | output | 1 | Program window in progress |
| wear_count | output | CW | Saturating count of program operations |

## Verification
`req_ready` and `host_rdata` depend on the inputs of the same cycle. `pgm_go`, the command fields and `wear_count` change in the cycle after the edge at which the commit is accepted. `pgm_busy` then stays high for PROG_CYCLES cycles counted from that same cycle. The bench drives its inputs just after each rising edge. A behavioural model advances at the same edge from those inputs and its own state. Every output is then compared with the model at the falling edge, which is the point at which all of these latencies have settled. The memory model applies a command at the edge that ends its `pgm_go` cycle, and the reference image is updated at that same edge.

// File: rtl/nvm_merge_pkg.sv
package nvm_merge_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   // Number of clock cycles covering a window given in microseconds (min 1)
   function automatic int unsigned window_cycles(input int unsigned clk_hz,
                                                 input int unsigned win_us);
      longint unsigned t;
      t = (longint'(clk_hz) * longint'(win_us)) / 64'd1_000_000;
      if (t < 64'd1) t = 64'd1;
      return int'(t);
   endfunction

endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
   parameter int unsigned CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned TW = $clog2(CYCLES + 1);
   localparam logic [TW-1:0] LOAD = TW'(CYCLES);

   logic [TW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)              remain <= '0;
      else if (start)          remain <= LOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R6
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R6

endmodule

// File: rtl/nvm_wear_counter.sv
module nvm_wear_counter #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] PEAK = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                     count <= '0;
      else if (inc && count != PEAK)  count <= count + 1'b1;
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count)); // R9
   AST_CNT_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      (count == PEAK) |=> (count == PEAK)); // R9
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && count != PEAK) |=> (count == $past(count) + 1'b1)); // R9

endmodule

// File: rtl/nvm_group_buffer.sv
module nvm_group_buffer
   import nvm_merge_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter int unsigned GROUP_BYTES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   // write side
   input  logic                          wr_en,
   input  logic                          load_new,
   input  logic                          clear,
   input  logic [AW-$clog2(GROUP_BYTES)-1:0] wr_grp,
   input  logic [$clog2(GROUP_BYTES)-1:0]    wr_lane,
   input  byte_t                         wr_byte,
   input  logic                          wr_diff,
   // pending group
   output logic [AW-$clog2(GROUP_BYTES)-1:0] pend_grp,
   output logic [BYTE_W*GROUP_BYTES-1:0] pend_data,
   output logic [GROUP_BYTES-1:0]        pend_mask,
   // overlay lookup
   input  logic [AW-$clog2(GROUP_BYTES)-1:0] rd_grp,
   input  logic [$clog2(GROUP_BYTES)-1:0]    rd_lane,
   output logic                          rd_hit,
   output byte_t                         rd_byte
);
   localparam int unsigned OFF_W = $clog2(GROUP_BYTES);
   localparam int unsigned GW    = AW - OFF_W;

   byte_t lane_q [GROUP_BYTES];

   always_ff @(posedge clk) begin
      if (!rst_n)        pend_grp <= '0;
      else if (load_new) pend_grp <= wr_grp;
   end

   for (genvar k = 0; k < GROUP_BYTES; k++) begin : g_lane
      logic hit_k;
      assign hit_k = wr_en && (wr_lane == OFF_W'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_mask[k] <= 1'b0;
            lane_q[k]    <= '0;
         end else if (hit_k) begin
            pend_mask[k] <= wr_diff;
            lane_q[k]    <= wr_byte;
         end else if (load_new || clear) begin
            pend_mask[k] <= 1'b0;
         end
      end

      assign pend_data[BYTE_W*k +: BYTE_W] = lane_q[k];
   end

   assign rd_hit  = (rd_grp == pend_grp) && pend_mask[rd_lane];
   assign rd_byte = lane_q[rd_lane];

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !wr_en) |=> (pend_mask == '0)); // R5
   AST_SAME_DATA_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_diff) |=> !pend_mask[$past(wr_lane)]); // R10

   logic unused_gw;
   assign unused_gw = (GW == 0);

endmodule

// File: rtl/nvm_write_merger.sv
module nvm_write_merger
   import nvm_merge_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter int unsigned GROUP_BYTES = 8,
   parameter int unsigned CW          = 16,
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned PROG_US     = 20_000,
   parameter int unsigned PROG_CYCLES = window_cycles(CLK_HZ, PROG_US)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [AW-1:0]                 req_addr,
   input  logic [7:0]                    req_data,
   input  logic                          flush_req,
   input  logic [AW-1:0]                 host_raddr,
   output logic [7:0]                    host_rdata,
   output logic [AW-1:0]                 mem_cmp_addr,
   input  logic [7:0]                    mem_cmp_data,
   output logic [AW-1:0]                 mem_look_addr,
   input  logic [7:0]                    mem_look_data,
   output logic                          pgm_go,
   output logic [AW-1:0]                 pgm_base,
   output logic [8*GROUP_BYTES-1:0]      pgm_data,
   output logic [GROUP_BYTES-1:0]        pgm_mask,
   output logic                          pgm_busy,
   output logic [CW-1:0]                 wear_count
);
   localparam int unsigned OFF_W = $clog2(GROUP_BYTES);
   localparam int unsigned GW    = AW - OFF_W;

   // elaboration-time parameter checks
   if (GROUP_BYTES < 2 || (GROUP_BYTES & (GROUP_BYTES - 1)) != 0) begin : g_bad_group
      $error("GROUP_BYTES must be a power of two of at least 2");
   end
   if (AW <= OFF_W) begin : g_bad_aw
      $error("AW must exceed the group offset width");
   end
   if (PROG_CYCLES < 1) begin : g_bad_cycles
      $error("PROG_CYCLES must be at least 1");
   end
   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end

   // request decode
   logic [GW-1:0]    req_grp;
   logic [OFF_W-1:0] req_lane;
   assign req_grp  = req_addr[AW-1:OFF_W];
   assign req_lane = req_addr[OFF_W-1:0];

   logic [GW-1:0]                  pend_grp;
   logic [8*GROUP_BYTES-1:0]       pend_data;
   logic [GROUP_BYTES-1:0]         pend_mask;
   logic                           pend_any;
   logic                           same_grp;
   logic                           idle;
   logic                           accept;
   logic                           do_flush;
   logic                           do_switch;
   logic                           commit;
   logic                           differs;
   logic                           ovl_hit;
   byte_t                          ovl_byte;

   assign idle      = !pgm_busy;
   assign req_ready = idle && !flush_req;
   assign accept    = req_valid && req_ready;
   assign pend_any  = |pend_mask;
   assign same_grp  = pend_any && (pend_grp == req_grp);
   assign do_flush  = idle && flush_req && pend_any;
   assign do_switch = accept && pend_any && !same_grp;
   assign commit    = do_flush || do_switch;

   assign mem_cmp_addr = req_addr;
   assign differs      = (req_data != mem_cmp_data);

   nvm_group_buffer #(
      .AW          (AW),
      .GROUP_BYTES (GROUP_BYTES)
   ) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (accept),
      .load_new  (accept && !same_grp),
      .clear     (do_flush),
      .wr_grp    (req_grp),
      .wr_lane   (req_lane),
      .wr_byte   (req_data),
      .wr_diff   (differs),
      .pend_grp  (pend_grp),
      .pend_data (pend_data),
      .pend_mask (pend_mask),
      .rd_grp    (host_raddr[AW-1:OFF_W]),
      .rd_lane   (host_raddr[OFF_W-1:0]),
      .rd_hit    (ovl_hit),
      .rd_byte   (ovl_byte)
   );

   // host read with pending overlay
   assign mem_look_addr = host_raddr;
   assign host_rdata    = ovl_hit ? ovl_byte : mem_look_data;

   // zero the lanes that are not enabled
   logic [8*GROUP_BYTES-1:0] cmd_data;
   for (genvar k = 0; k < GROUP_BYTES; k++) begin : g_cmd_lane
      assign cmd_data[8*k +: 8] = pend_mask[k] ? pend_data[8*k +: 8] : 8'h00;
   end

   // program command register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pgm_go   <= 1'b0;
         pgm_base <= '0;
         pgm_data <= '0;
         pgm_mask <= '0;
      end else begin
         pgm_go <= commit;
         if (commit) begin
            pgm_base <= {pend_grp, {OFF_W{1'b0}}};
            pgm_data <= cmd_data;
            pgm_mask <= pend_mask;
         end
      end
   end

   nvm_prog_timer #(
      .CYCLES (PROG_CYCLES)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit),
      .busy  (pgm_busy)
   );

   nvm_wear_counter #(
      .CW (CW)
   ) i_count (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (commit),
      .count (wear_count)
   );

   AST_GO_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |-> (pgm_mask != '0)); // R1
   AST_SWITCH_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pend_any && (pend_grp != req_grp)) |=> pgm_go); // R4
   AST_FLUSH_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !pgm_busy && pend_any) |=> (pgm_go && pend_mask == '0)); // R5
   AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |=> !pgm_go); // R6
   AST_GO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |-> (pgm_busy && !req_ready)); // R6
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |-> (pgm_base[OFF_W-1:0] == '0)); // R2

endmodule

// File: tb/test_nvm_write_merger.sv
module test_nvm_write_merger;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 12;
   localparam int GB    = 8;
   localparam int CW    = 10;
   localparam int PCYC  = 3;
   localparam int DEPTH = 1 << AW;
   localparam int CMAX  = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic flush_req = 1'b0;
   logic [AW-1:0] host_raddr = '0;
   logic [7:0] host_rdata;
   logic [AW-1:0] mem_cmp_addr, mem_look_addr;
   logic [7:0] mem_cmp_data, mem_look_data;
   logic pgm_go, pgm_busy;
   logic [AW-1:0] pgm_base;
   logic [8*GB-1:0] pgm_data;
   logic [GB-1:0] pgm_mask;
   logic [CW-1:0] wear_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_write_merger #(
      .AW (AW), .GROUP_BYTES (GB), .CW (CW), .PROG_CYCLES (PCYC)
   ) i_nvm_write_merger (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_addr (req_addr), .req_data (req_data),
      .flush_req (flush_req),
      .host_raddr (host_raddr), .host_rdata (host_rdata),
      .mem_cmp_addr (mem_cmp_addr), .mem_cmp_data (mem_cmp_data),
      .mem_look_addr (mem_look_addr), .mem_look_data (mem_look_data),
      .pgm_go (pgm_go), .pgm_base (pgm_base), .pgm_data (pgm_data),
      .pgm_mask (pgm_mask), .pgm_busy (pgm_busy), .wear_count (wear_count)
   );

   // memory model driven by the command port
   logic [7:0] flash [DEPTH];
   initial for (int i = 0; i < DEPTH; i++) flash[i] = 8'hFF;
   assign mem_cmp_data  = flash[mem_cmp_addr];
   assign mem_look_data = flash[mem_look_addr];
   always @(posedge clk) begin
      if (pgm_go)
         for (int k = 0; k < GB; k++)
            if (pgm_mask[k]) flash[int'(pgm_base) + k] <= pgm_data[8*k +: 8];
   end

   int total = 0;
   int bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   logic [7:0] ref_img [DEPTH];
   initial for (int i = 0; i < DEPTH; i++) ref_img[i] = 8'hFF;
   int m_grp = 0;
   logic [7:0] m_data [GB];
   logic [GB-1:0] m_mask = '0;
   int m_t = 0;
   int m_cnt = 0;
   bit e_go = 0;
   int e_base = 0;
   logic [8*GB-1:0] e_data = '0;
   logic [GB-1:0] e_mask = '0;
   initial for (int k = 0; k < GB; k++) m_data[k] = 8'h00;

   task automatic m_commit();
      e_go = 1;
      e_base = m_grp * GB;
      e_mask = m_mask;
      for (int k = 0; k < GB; k++) e_data[8*k +: 8] = m_mask[k] ? m_data[k] : 8'h00;
      m_t = PCYC;
      if (m_cnt < CMAX) m_cnt++;
      m_mask = '0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask = '0; m_t = 0; m_cnt = 0; e_go = 0;
      end else begin
         if (e_go)
            for (int k = 0; k < GB; k++)
               if (e_mask[k]) ref_img[e_base + k] = e_data[8*k +: 8];
         e_go = 0;
         if (m_t > 0) m_t--;
         else if (flush_req) begin
            if (m_mask != '0) m_commit();
         end else if (req_valid) begin
            int g, ln;
            bit same;
            g = int'(req_addr) / GB;
            ln = int'(req_addr) % GB;
            same = (m_mask != '0) && (g == m_grp);
            if (m_mask != '0 && !same) m_commit();
            if (!same) begin m_mask = '0; m_grp = g; end
            m_data[ln] = req_data;
            m_mask[ln] = (req_data != ref_img[int'(req_addr)]);
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int a;
         logic [7:0] exp_rd;
         a = int'(host_raddr);
         exp_rd = ((a / GB) == m_grp && m_mask[a % GB]) ? m_data[a % GB] : ref_img[a];
         chk("R7/R6 req_ready", 64'(req_ready), 64'((m_t == 0) && !flush_req));
         chk("R6 pgm_busy", 64'(pgm_busy), 64'(m_t > 0));
         chk("R4 pgm_go", 64'(pgm_go), 64'(e_go));
         if (e_go) begin
            chk("R4 pgm_base", 64'(pgm_base), 64'(e_base));
            chk("R2 pgm_mask", 64'(pgm_mask), 64'(e_mask));
            chk("R2 pgm_data", pgm_data, e_data);
         end
         chk("R9 wear_count", 64'(wear_count), 64'(m_cnt));
         chk("R8 host_rdata", 64'(host_rdata), 64'(exp_rd));
      end
   end

   // stimulus helpers
   task automatic put_byte(input int addr, input logic [7:0] d);
      bit r;
      req_valid = 1'b1;
      req_addr  = AW'(addr);
      req_data  = d;
      do begin
         @(negedge clk); r = req_ready;
         @(posedge clk); #1;
      end while (!r);
      req_valid = 1'b0;
   endtask

   task automatic flush_now();
      bit idle;
      flush_req = 1'b1;
      do begin
         @(negedge clk); idle = !pgm_busy;
         @(posedge clk); #1;
      end while (!idle);
      flush_req = 1'b0;
   endtask

   task automatic settle();
      repeat (PCYC + 2) @(posedge clk);
      #1;
   endtask

   int goes_seen = 0;
   always @(negedge clk) if (rst_n && pgm_go) goes_seen++;

   initial begin : main
      int c0, g0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset ready", 64'(req_ready), 64'd1);
      chk("R6 reset busy", 64'(pgm_busy), 64'd0);
      chk("R9 reset count", 64'(wear_count), 64'd0);
      chk("R4 reset go", 64'(pgm_go), 64'd0);
      @(posedge clk); #1;

      // R3: full sequential download of changed data
      g0 = goes_seen;
      for (int i = 0; i < DEPTH; i++) put_byte(i, 8'(i) ^ 8'h5A);
      flush_now(); settle();
      @(negedge clk);
      chk("R3 count after 4096 bytes", 64'(wear_count), 64'd512);
      chk("R3 program strobes", 64'(goes_seen - g0), 64'd512);
      @(posedge clk); #1;

      // R1: rewrite identical data, nothing programmed
      c0 = int'(wear_count);
      for (int i = 0; i < 64; i++) put_byte(i, 8'(i) ^ 8'h5A);
      flush_now(); settle();
      @(negedge clk);
      chk("R1 unchanged bytes", 64'(wear_count), 64'(c0));
      @(posedge clk); #1;

      // R10: change then restore one lane
      put_byte(100, 8'h00);
      put_byte(100, 8'(100) ^ 8'h5A);
      flush_now(); settle();
      @(negedge clk);
      chk("R10 restored lane", 64'(wear_count), 64'(c0));
      @(posedge clk); #1;

      // R5: flush with empty mask
      flush_now(); settle();
      @(negedge clk);
      chk("R5 empty flush", 64'(wear_count), 64'(c0));
      @(posedge clk); #1;

      // R8: overlay read of a pending byte and a neighbour
      put_byte(200, 8'h11);
      host_raddr = AW'(200);
      @(negedge clk);
      chk("R8 pending byte", 64'(host_rdata), 64'h11);
      host_raddr = AW'(201);
      #1;
      chk("R8 stored neighbour", 64'(host_rdata), 64'(8'(201) ^ 8'h5A));
      @(posedge clk); #1;
      flush_now(); settle();

      // R2 / R4: scattered lanes, then a switch to another group
      c0 = int'(wear_count);
      put_byte(12'h30F, 8'hA1);
      put_byte(12'h308, 8'hB2);
      put_byte(12'h30A, 8'hC3);
      put_byte(12'h30F, 8'hD4);
      put_byte(12'h400, 8'hE5);
      @(negedge clk);
      chk("R4 switch strobe", 64'(pgm_go), 64'd1);
      chk("R2 scattered mask", 64'(pgm_mask), 64'h85);
      chk("R2 last write wins", 64'(pgm_data[63:56]), 64'hD4);
      @(posedge clk); #1;
      flush_now(); settle();
      @(negedge clk);
      chk("R2 two commits", 64'(wear_count), 64'(c0 + 2));
      @(posedge clk); #1;

      // R7: flush and request together
      put_byte(12'h500, 8'h01);
      req_valid = 1'b1; req_addr = AW'(12'h501); req_data = 8'h02; flush_req = 1'b1;
      @(negedge clk);
      chk("R7 flush blocks ready", 64'(req_ready), 64'd0);
      @(posedge clk); #1;
      flush_req = 1'b0; req_valid = 1'b0;
      settle();

      // R9: second full download drives the count to saturation
      for (int i = 0; i < DEPTH; i++) put_byte(i, 8'(i) ^ 8'hC3);
      flush_now(); settle();
      @(negedge clk);
      chk("R9 saturated count", 64'(wear_count), 64'(CMAX));
      @(posedge clk); #1;

      begin
         int mism = 0;
         for (int i = 0; i < DEPTH; i++) if (flash[i] !== ref_img[i]) mism++;
         chk("R2 memory image", 64'(mism), 64'd0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule